// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Slave Port

This block is a slave-only stereo serial audio port. An external master supplies the bit clock, the word select and the receive data line; the port samples all three into the system clock domain, recovers a left and a right PCM sample per frame and presents them as parallel words with a one-cycle valid strobe. At the same time it serializes a parallel stereo pair onto its transmit data line in step with the same bit clock and word select.

Three framing alignments are handled by one engine: standard I2S (MSB one bit clock after the word-select edge), left-justified (MSB on the word-select edge) and right-justified (LSB on the last bit clock of the half-frame). The sample width is 16, 20 or 24 bits, MSB first in every case. Bits of a half-frame outside the programmed sample are ignored on receive and sent as zero on transmit. The right-justified transmitter measures the previous half-frame length to place its first bit.

Top module: `audio_serial_slave`

## Requirements
- R1: After reset `rx_valid_o` is 0, `sdata_o` is 0 and both `rx_left_o` and `rx_right_o` are zero.
- R2: With `fmt_i` = 0 (I2S, also used for code 3) the received MSB is the bit sampled on the second bit-clock rising edge after a word-select change (the rising edge that first sees the new word-select level counts as the first).
- R3: With `fmt_i` = 1 (left-justified) the received MSB is the bit sampled on the first rising edge that sees the new word-select level.
- R4: With `fmt_i` = 2 (right-justified) the received LSB is the bit sampled on the last rising edge before the next word-select change.
- R5: `wsize_i` = 0, 1, 2 select 16, 20, 24 bit samples (3 also means 24); received words are right-aligned in the 24-bit outputs, upper bits zero, and bits of the half-frame outside the sample window have no effect on them.
- R6: Word select low carries the left sample and high the right sample; `rx_valid_o` pulses for exactly one clock when a left half followed by a right half has completed, in the third system clock edge counted from the first edge that samples the bit-clock rising edge on which word select returns low, and `rx_left_o`/`rx_right_o` change only with that pulse.
- R7: A right half that is not preceded by a complete left half since reset produces no valid pulse.
- R8: Transmit bits go out MSB first with the same alignment as receive for each format, and `sdata_o` changes only three system clock edges after a bit-clock falling edge is first sampled.
- R9: Transmit bit slots outside the sample window are driven as 0.
- R10: The transmitted pair is the value of `tx_left_i`/`tx_right_i` captured when the falling edge that starts a left half is seen; later changes during the frame have no effect until the next left half.
- R11: In right-justified transmit the first data slot is the previous half-frame length minus the sample width, so the LSB lands on the last bit clock of the half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | External serial bit clock |
| lrck_i | input | 1 | External word select, low = left, high = right |
| sdata_i | input | 1 | Serial receive data |
| fmt_i | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 as I2S |
| wsize_i | input | 2 | Sample width: 0 = 16, 1 = 20, 2/3 = 24 bits |
| tx_left_i | input | 24 | Left sample to transmit, right-aligned |
| tx_right_i | input | 24 | Right sample to transmit, right-aligned |
| sdata_o | output | 1 | Serial transmit data |
| rx_left_o | output | 24 | Last received left sample, right-aligned |
| rx_right_o | output | 24 | Last received right sample, right-aligned |
| rx_valid_o | output | 1 | One-cycle strobe for a new received pair |

## Verification
The port is driven with every framing at more than one width and with 32-slot and 24-slot half-frames, so a window placed one slot early or late, or counted from the wrong end, shows up as a shifted word. Padding slots on the receive line carry random bits, which separates a design that masks the window from one that shifts in everything, and the transmit inputs are scrambled during the right half to tell a latched pair from a live one. The leading half-frame after reset is a lone right half, which exposes any strobe issued for an incomplete pair, and the strobe is compared every clock against the predicted cycle.

// File: rtl/asp_pkg.sv
package asp_pkg;

   typedef enum logic [1:0] {
      FMT_I2S   = 2'd0,
      FMT_LEFT  = 2'd1,
      FMT_RIGHT = 2'd2,
      FMT_ALT   = 2'd3
   } fmt_e;

endpackage

// File: rtl/asp_sync.sv
module asp_sync #(
   parameter int N      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d_i,
   output logic [N-1:0] q_o
);

   logic [N-1:0] chain [STAGES];

   initial begin
      assert (STAGES >= 2) else $error("asp_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d_i;
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[g] <= '0;
         else        chain[g] <= chain[g-1];
      end
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/asp_rx.sv
module asp_rx
   import asp_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int SLOT_W   = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rise_i,
   input  logic                ws_i,
   input  logic                sd_i,
   input  fmt_e                fmt_i,
   input  logic [SLOT_W-1:0]   wlen_i,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                valid_o
);

   logic                ws_q, seen_q, left_ok_q;
   logic [SLOT_W-1:0]   slot_q, nslot, start;
   logic [SAMPLE_W-1:0] shreg_q, left_hold_q, mask, word;
   logic [SLOT_W:0]     win_end;
   logic                chg, in_win;

   function automatic logic [SLOT_W-1:0] sat_inc(input logic [SLOT_W-1:0] v);
      return (v == '1) ? v : v + 1'b1;
   endfunction

   always_comb begin
      chg     = (ws_i != ws_q);
      nslot   = chg ? '0 : sat_inc(slot_q);
      start   = (fmt_i == FMT_LEFT || fmt_i == FMT_RIGHT) ? '0 : SLOT_W'(1);
      win_end = {1'b0, start} + {1'b0, wlen_i};
      if (fmt_i == FMT_RIGHT) in_win = 1'b1;
      else                    in_win = (nslot >= start) && ({1'b0, nslot} < win_end);
      for (int i = 0; i < SAMPLE_W; i++) mask[i] = (SLOT_W'(i) < wlen_i);
      word = shreg_q & mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ws_q        <= 1'b0;
         seen_q      <= 1'b0;
         left_ok_q   <= 1'b0;
         slot_q      <= '0;
         shreg_q     <= '0;
         left_hold_q <= '0;
         left_o      <= '0;
         right_o     <= '0;
         valid_o     <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (rise_i) begin
            ws_q   <= ws_i;
            slot_q <= nslot;
            seen_q <= seen_q | chg;
            if (chg)         shreg_q <= in_win ? {{(SAMPLE_W-1){1'b0}}, sd_i} : '0;
            else if (in_win) shreg_q <= {shreg_q[SAMPLE_W-2:0], sd_i};
            if (chg && seen_q) begin
               if (!ws_q) begin
                  left_hold_q <= word;
                  left_ok_q   <= 1'b1;
               end else begin
                  left_ok_q <= 1'b0;
                  if (left_ok_q) begin
                     left_o  <= left_hold_q;
                     right_o <= word;
                     valid_o <= 1'b1;
                  end
               end
            end
         end
      end
   end

   // R6: the strobe never lasts more than one clock
   p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R6: outputs hold between strobes
   p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> ($stable(left_o) && $stable(right_o)));

   // R5: no bits above the programmed width reach the outputs
   p_width_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (((left_o | right_o) & ~mask) == '0));

endmodule

// File: rtl/asp_tx.sv
module asp_tx
   import asp_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int SLOT_W   = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fall_i,
   input  logic                ws_i,
   input  fmt_e                fmt_i,
   input  logic [SLOT_W-1:0]   wlen_i,
   input  logic [SAMPLE_W-1:0] tx_left_i,
   input  logic [SAMPLE_W-1:0] tx_right_i,
   output logic                sd_o
);

   logic                ws_q;
   logic [SLOT_W-1:0]   slot_q, len_q, nslot, lenx, start, off, idx;
   logic [SLOT_W:0]     win_end;
   logic [SAMPLE_W-1:0] hold_l_q, hold_r_q, smp, shifted;
   logic                chg, in_win;

   function automatic logic [SLOT_W-1:0] sat_inc(input logic [SLOT_W-1:0] v);
      return (v == '1) ? v : v + 1'b1;
   endfunction

   always_comb begin
      chg   = (ws_i != ws_q);
      nslot = chg ? '0 : sat_inc(slot_q);
      lenx  = chg ? sat_inc(slot_q) : len_q;
      case (fmt_i)
         FMT_LEFT:  start = '0;
         FMT_RIGHT: start = (lenx >= wlen_i) ? lenx - wlen_i : '0;
         default:   start = SLOT_W'(1);
      endcase
      win_end = {1'b0, start} + {1'b0, wlen_i};
      in_win  = (nslot >= start) && ({1'b0, nslot} < win_end);
      off     = nslot - start;
      idx     = wlen_i - 1'b1 - off;
      if (chg && !ws_i) smp = tx_left_i;
      else if (ws_i)    smp = hold_r_q;
      else              smp = hold_l_q;
      shifted = smp >> idx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ws_q     <= 1'b0;
         slot_q   <= '0;
         len_q    <= '0;
         hold_l_q <= '0;
         hold_r_q <= '0;
         sd_o     <= 1'b0;
      end else if (fall_i) begin
         ws_q   <= ws_i;
         slot_q <= nslot;
         if (chg) len_q <= lenx;
         if (chg && !ws_i) begin
            hold_l_q <= tx_left_i;
            hold_r_q <= tx_right_i;
         end
         sd_o <= in_win & shifted[0];
      end
   end

   // R8: the line moves only on a sampled falling edge
   p_tx_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_i |=> $stable(sd_o));

endmodule

// File: rtl/audio_serial_slave.sv
module audio_serial_slave
   import asp_pkg::*;
#(
   parameter int WIDTH_A     = 16,
   parameter int WIDTH_B     = 20,
   parameter int WIDTH_C     = 24,
   parameter int SLOT_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bclk_i,
   input  logic               lrck_i,
   input  logic               sdata_i,
   input  logic [1:0]         fmt_i,
   input  logic [1:0]         wsize_i,
   input  logic [WIDTH_C-1:0] tx_left_i,
   input  logic [WIDTH_C-1:0] tx_right_i,
   output logic               sdata_o,
   output logic [WIDTH_C-1:0] rx_left_o,
   output logic [WIDTH_C-1:0] rx_right_o,
   output logic               rx_valid_o
);

   localparam int SAMPLE_W = WIDTH_C;

   initial begin
      assert (WIDTH_A > 1 && WIDTH_A < WIDTH_B && WIDTH_B < WIDTH_C)
         else $error("audio_serial_slave: widths must be increasing");
      assert ((2 ** SLOT_W) > WIDTH_C + 1)
         else $error("audio_serial_slave: SLOT_W too small for widest sample");
   end

   logic [2:0]        sync_q;
   logic              bclk_s, ws_s, sd_s, bclk_d, rise, fall;
   logic [SLOT_W-1:0] wlen;
   fmt_e              fmt;

   asp_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({bclk_i, lrck_i, sdata_i}),
      .q_o   (sync_q)
   );

   assign {bclk_s, ws_s, sd_s} = sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_d <= 1'b0;
      else        bclk_d <= bclk_s;
   end

   assign rise = bclk_s & ~bclk_d;
   assign fall = ~bclk_s & bclk_d;
   assign fmt  = fmt_e'(fmt_i);

   always_comb begin
      case (wsize_i)
         2'd0:    wlen = SLOT_W'(WIDTH_A);
         2'd1:    wlen = SLOT_W'(WIDTH_B);
         default: wlen = SLOT_W'(WIDTH_C);
      endcase
   end

   asp_rx #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise_i  (rise),
      .ws_i    (ws_s),
      .sd_i    (sd_s),
      .fmt_i   (fmt),
      .wlen_i  (wlen),
      .left_o  (rx_left_o),
      .right_o (rx_right_o),
      .valid_o (rx_valid_o)
   );

   asp_tx #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .fall_i     (fall),
      .ws_i       (ws_s),
      .fmt_i      (fmt),
      .wlen_i     (wlen),
      .tx_left_i  (tx_left_i),
      .tx_right_i (tx_right_i),
      .sd_o       (sdata_o)
   );

endmodule

// File: tb/audio_serial_slave_bench.sv
`timescale 1ns/1ps
module audio_serial_slave_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b1, lrck = 1'b0, sdin = 1'b0;
   logic [1:0]  fmt = 2'd0, wsize = 2'd0;
   logic [23:0] tx_l = '0, tx_r = '0;
   logic        sdout, rx_valid;
   logic [23:0] rx_left, rx_right;

   always #2.5 clk = ~clk;

   audio_serial_slave u_audio_serial_slave (
      .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .lrck_i(lrck), .sdata_i(sdin),
      .fmt_i(fmt), .wsize_i(wsize), .tx_left_i(tx_l), .tx_right_i(tx_r),
      .sdata_o(sdout), .rx_left_o(rx_left), .rx_right_o(rx_right),
      .rx_valid_o(rx_valid)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int nchk = 0, nerr = 0;
   int exp_at = -1;
   logic [23:0] exp_l = '0, exp_r = '0;
   int cur_mode = 0, cur_w = 16, cur_L = 32;
   bit done = 0;

   function automatic string mtag(int m);
      if (m == 1) return "R3";
      if (m == 2) return "R4";
      return "R2";
   endfunction

   function automatic int start_slot(int m, int L, int W);
      if (m == 1) return 0;
      if (m == 2) return L - W;
      return 1;
   endfunction

   task automatic check_valid();
      bit e;
      e = (cyc == exp_at);
      if (e || rx_valid) begin
         nchk++;
         if (rx_valid !== e) begin
            nerr++;
            $display("FAIL R6/R7 strobe at cycle %0d: actual %0b expected %0b", cyc, rx_valid, e);
         end else begin
            nchk++;
            if (rx_left !== exp_l || rx_right !== exp_r) begin
               nerr++;
               $display("FAIL %s/R5 pair: actual %h/%h expected %h/%h",
                        mtag(cur_mode), rx_left, rx_right, exp_l, exp_r);
            end
         end
      end
   endtask

   task automatic tick();
      @(negedge clk);
      check_valid();
   endtask

   task automatic send_bit(logic ws, logic sd, bit chk, logic expb, string tg, bit arm);
      tick();
      bclk = 1'b0; lrck = ws; sdin = sd;
      repeat (3) tick();
      tick();
      if (chk) begin
         nchk++;
         if (sdout !== expb) begin
            nerr++;
            $display("FAIL %s tx bit: actual %0b expected %0b", tg, sdout, expb);
         end
      end
      bclk = 1'b1;
      if (arm) exp_at = cyc + 3;
      repeat (3) tick();
   endtask

   task automatic send_half(logic ws, logic [23:0] rxs, logic [23:0] txs, bit chk, bit arm);
      int st;
      st = start_slot(cur_mode, cur_L, cur_w);
      for (int s = 0; s < cur_L; s++) begin
         bit    inw;
         logic  rb, tb;
         string tg;
         inw = (s >= st) && (s < st + cur_w);
         rb  = inw ? rxs[cur_w-1-(s-st)] : 1'($urandom_range(0, 1));
         tb  = inw ? txs[cur_w-1-(s-st)] : 1'b0;
         if (!inw)              tg = "R9";
         else if (cur_mode == 2) tg = "R8/R10/R11";
         else                   tg = "R8/R10";
         send_bit(ws, rb, chk, tb, tg, arm && (s == 0));
      end
   endtask

   task automatic run_cfg(int m, int wsel, int L, int nfr);
      logic [23:0] msk, pl, pr, rl, rr, tl, tr;
      bit have;
      cur_mode = m; cur_L = L;
      cur_w = (wsel == 0) ? 16 : (wsel == 1) ? 20 : 24;
      msk = 24'((64'd1 << cur_w) - 1);
      fmt = 2'(m); wsize = 2'(wsel);
      rst_n = 1'b0; bclk = 1'b1; lrck = 1'b0; sdin = 1'b0; exp_at = -1;
      repeat (4) tick();
      rst_n = 1'b1;
      repeat (6) tick();
      send_half(1'b1, $urandom, 24'd0, 1'b0, 1'b0);   // lone right half: R7
      have = 0; pl = '0; pr = '0;
      for (int f = 0; f < nfr; f++) begin
         rl = $urandom & msk; rr = $urandom & msk;
         tl = $urandom & msk; tr = $urandom & msk;
         tx_l = tl; tx_r = tr;
         exp_l = pl; exp_r = pr;
         send_half(1'b0, rl, tl, 1'b1, have);
         tx_l = ~tl; tx_r = ~tr;                         // R10: ignored mid-frame
         send_half(1'b1, rr, tr, 1'b1, 1'b0);
         pl = rl; pr = rr; have = 1;
      end
      exp_l = pl; exp_r = pr;
      send_bit(1'b0, 1'b0, 1'b0, 1'b0, "", 1'b1);
      repeat (8) tick();
   endtask

   initial begin
      repeat (3) tick();
      // R1: reset state
      nchk++; if (rx_valid !== 1'b0) begin nerr++; $display("FAIL R1 rx_valid: actual %0b expected 0", rx_valid); end
      nchk++; if (sdout !== 1'b0) begin nerr++; $display("FAIL R1 sdata_o: actual %0b expected 0", sdout); end
      nchk++; if (rx_left !== '0) begin nerr++; $display("FAIL R1 rx_left: actual %h expected 0", rx_left); end
      nchk++; if (rx_right !== '0) begin nerr++; $display("FAIL R1 rx_right: actual %h expected 0", rx_right); end
      run_cfg(0, 0, 32, 3);
      run_cfg(1, 1, 32, 3);
      run_cfg(2, 2, 32, 3);
      run_cfg(0, 2, 32, 3);
      run_cfg(2, 0, 32, 3);
      run_cfg(1, 2, 24, 3);
      run_cfg(2, 1, 24, 3);
      run_cfg(3, 3, 32, 2);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

endmodule